// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Unit

This unit sits between an in-order queue of decoded instructions and two logical execution pipes. Each cycle it looks at the two oldest queue entries: slot 0 is the older and slot 1 the younger. It decides whether none, one or both of them issue. Each issued instruction is steered to the function pipe or to the memory pipe. The result is registered: one valid bit and one slot select per pipe, plus a count the queue uses to pop the entries it has consumed.

Each instruction brings an issue class, a multiply/divide flag, a destination register with a write enable, and up to `NSRC` source registers, each with its own read enable. The two pipes accept different sets of classes. A plain integer operation is the only kind that fits in either pipe, so the unit chooses where an older integer goes by looking at what the younger instruction needs.

Dependencies between the two instructions of a pair are resolved here. Results still pending from earlier cycles arrive as a per-register busy vector, and an instruction whose source is busy waits.

Top module: `dual_issue_pair`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, all outputs are 0.
- R2: The class code is 0 for integer, 1 for load/store, 2 for branch and 3 for floating point. An integer with `md` set is a multiply/divide. The function pipe takes integer, multiply/divide, branch and floating point. The memory pipe takes only plain integer and load/store. The `md` flag has no effect on classes other than integer.
- R3: At most one instruction issues per pipe and at most two per cycle. The count output equals the number of valid pipe outputs. When both pipes are valid, their slot selects differ (select 0 is the older slot, 1 the younger).
- R4: Issue is in order. The younger instruction issues only if the older one issues in the same cycle, and when exactly one instruction issues it is the older.
- R5: When both instructions are plain integers, the older goes to the function pipe and the younger to the memory pipe. An older plain integer goes to the memory pipe only when a younger instruction is present (queue count of at least 2) and that younger instruction can use only the function pipe.
- R6: When both instructions can use only the same pipe, only the older issues.
- R7: The younger instruction does not issue if the older one writes a nonzero register that the younger reads through an enabled source or also writes. Register 0 never creates a dependency.
- R8: An instruction with an enabled source whose busy bit is set does not issue, and neither does anything younger. Register 0 is never treated as busy.
- R9: A queue count of 0 issues nothing, a count of 1 considers only slot 0, and a count of 2 or 3 considers both slots.
- R10: A high `stall_i` forces zero issue for that cycle.
- R11: The outputs present the decision for the inputs sampled at the previous rising clock edge, and hold it for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Forces zero issue |
| q_cnt_i | input | 2 | Number of valid queue entries (3 is treated as 2) |
| busy_i | input | NREG | Busy bit per register, for results still pending |
| s0_cls_i | input | 2 | Issue class of the older instruction |
| s0_md_i | input | 1 | Multiply/divide flag of the older instruction |
| s0_wr_i | input | 1 | Older instruction writes a register |
| s0_dst_i | input | RW | Destination register of the older instruction |
| s0_rd_i | input | NSRC | Read enable for each source of the older instruction |
| s0_src_i | input | NSRC*RW | Source registers of the older instruction, source k at bits [k*RW +: RW] |
| s1_cls_i | input | 2 | Issue class of the younger instruction |
| s1_md_i | input | 1 | Multiply/divide flag of the younger instruction |
| s1_wr_i | input | 1 | Younger instruction writes a register |
| s1_dst_i | input | RW | Destination register of the younger instruction |
| s1_rd_i | input | NSRC | Read enable for each source of the younger instruction |
| s1_src_i | input | NSRC*RW | Source registers of the younger instruction |
| f_vld_o | output | 1 | Function pipe receives an instruction |
| f_sel_o | output | 1 | Slot steered to the function pipe |
| m_vld_o | output | 1 | Memory pipe receives an instruction |
| m_sel_o | output | 1 | Slot steered to the memory pipe |
| cnt_o | output | 2 | Entries consumed from the queue |

`NREG` must be a power of two, and RW = log2(NREG).

## Verification
The bench builds the unit with `NREG` = 8 and `NSRC` = 2. With only eight registers, randomly drawn register fields often hit the same register, so many pairs carry a dependency, a busy source, or a read of register 0. With two sources, each source position is checked separately for a dependency and for a busy bit. Directed pairs cover each class combination that forces a steering choice, and a long random run covers how queue count, stall, busy bits and classes interact.

// File: rtl/pair_pkg.sv
package pair_pkg;
  typedef enum logic [1:0] {
    CLS_INT  = 2'd0,
    CLS_LDST = 2'd1,
    CLS_BR   = 2'd2,
    CLS_FP   = 2'd3
  } cls_e;

  typedef struct packed {
    logic f_ok;
    logic m_ok;
  } pipe_mask_t;
endpackage

// File: rtl/pair_class_decode.sv
module pair_class_decode
  import pair_pkg::*;
(
  input  logic [1:0] cls_i,
  input  logic       md_i,
  output pipe_mask_t mask_o
);
  always_comb begin
    mask_o = '0;
    unique case (cls_e'(cls_i))
      CLS_INT: begin
        mask_o.f_ok = 1'b1;
        mask_o.m_ok = ~md_i;
      end
      CLS_LDST: mask_o.m_ok = 1'b1;
      CLS_BR:   mask_o.f_ok = 1'b1;
      CLS_FP:   mask_o.f_ok = 1'b1;
      default:  mask_o = '0;
    endcase
  end
endmodule

// File: rtl/pair_hazard.sv
module pair_hazard #(
  parameter int NREG = 32,
  parameter int NSRC = 2,
  localparam int RW  = $clog2(NREG)
) (
  input  logic [NREG-1:0]    busy_i,
  input  logic               s0_wr_i,
  input  logic [RW-1:0]      s0_dst_i,
  input  logic [NSRC-1:0]    s0_rd_i,
  input  logic [NSRC*RW-1:0] s0_src_i,
  input  logic               s1_wr_i,
  input  logic [RW-1:0]      s1_dst_i,
  input  logic [NSRC-1:0]    s1_rd_i,
  input  logic [NSRC*RW-1:0] s1_src_i,
  output logic               blk0_o,
  output logic               blk1_o,
  output logic               dep_o
);
  logic [NSRC-1:0] hit0, hit1, raw;
  logic            dst0_live;

  assign dst0_live = s0_wr_i && (s0_dst_i != '0);

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    logic [RW-1:0] src0, src1;
    assign src0   = s0_src_i[k*RW +: RW];
    assign src1   = s1_src_i[k*RW +: RW];
    assign hit0[k] = s0_rd_i[k] && (src0 != '0) && busy_i[src0];
    assign hit1[k] = s1_rd_i[k] && (src1 != '0) && busy_i[src1];
    assign raw[k]  = s1_rd_i[k] && (src1 == s0_dst_i);
  end

  assign blk0_o = |hit0;
  assign blk1_o = |hit1;
  // WAW is held back too, so the pipes never retire two writes to one register out of order
  assign dep_o  = dst0_live && ((|raw) || (s1_wr_i && (s1_dst_i == s0_dst_i)));
endmodule

// File: rtl/pair_steer.sv
module pair_steer
  import pair_pkg::*;
(
  input  logic       av0_i,
  input  logic       av1_i,
  input  logic       blk0_i,
  input  logic       blk1_i,
  input  logic       dep_i,
  input  pipe_mask_t mask0_i,
  input  pipe_mask_t mask1_i,
  output logic       f_vld_o,
  output logic       f_sel_o,
  output logic       m_vld_o,
  output logic       m_sel_o,
  output logic [1:0] cnt_o
);
  logic iss0, iss1, p0_m, fonly1;

  assign fonly1 = mask1_i.f_ok & ~mask1_i.m_ok;
  // older integer yields the function pipe to a younger function-only op
  assign p0_m   = mask0_i.m_ok & (~mask0_i.f_ok | (av1_i & fonly1));
  assign iss0   = av0_i & ~blk0_i & (mask0_i.f_ok | mask0_i.m_ok);
  assign iss1   = iss0 & av1_i & ~blk1_i & ~dep_i & (p0_m ? mask1_i.f_ok : mask1_i.m_ok);

  assign f_vld_o = (iss0 & ~p0_m) | (iss1 & p0_m);
  assign f_sel_o = iss1 & p0_m;
  assign m_vld_o = (iss0 & p0_m) | (iss1 & ~p0_m);
  assign m_sel_o = iss1 & ~p0_m;
  assign cnt_o   = {1'b0, iss0} + {1'b0, iss1};
endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
  import pair_pkg::*;
#(
  parameter int NREG = 32,
  parameter int NSRC = 2,
  localparam int RW  = $clog2(NREG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stall_i,
  input  logic [1:0]         q_cnt_i,
  input  logic [NREG-1:0]    busy_i,
  input  logic [1:0]         s0_cls_i,
  input  logic               s0_md_i,
  input  logic               s0_wr_i,
  input  logic [RW-1:0]      s0_dst_i,
  input  logic [NSRC-1:0]    s0_rd_i,
  input  logic [NSRC*RW-1:0] s0_src_i,
  input  logic [1:0]         s1_cls_i,
  input  logic               s1_md_i,
  input  logic               s1_wr_i,
  input  logic [RW-1:0]      s1_dst_i,
  input  logic [NSRC-1:0]    s1_rd_i,
  input  logic [NSRC*RW-1:0] s1_src_i,
  output logic               f_vld_o,
  output logic               f_sel_o,
  output logic               m_vld_o,
  output logic               m_sel_o,
  output logic [1:0]         cnt_o
);
  localparam int NSLOT = 2;

  logic [1:0]  cls_a [NSLOT];
  logic        md_a  [NSLOT];
  pipe_mask_t  mask_a[NSLOT];
  logic        av0, av1, blk0, blk1, dep;
  logic        f_vld_d, f_sel_d, m_vld_d, m_sel_d;
  logic [1:0]  cnt_d;

  assign cls_a[0] = s0_cls_i;
  assign cls_a[1] = s1_cls_i;
  assign md_a[0]  = s0_md_i;
  assign md_a[1]  = s1_md_i;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    pair_class_decode i_dec (
      .cls_i (cls_a[s]),
      .md_i  (md_a[s]),
      .mask_o(mask_a[s])
    );
  end

  pair_hazard #(.NREG(NREG), .NSRC(NSRC)) i_haz (
    .busy_i  (busy_i),
    .s0_wr_i (s0_wr_i),
    .s0_dst_i(s0_dst_i),
    .s0_rd_i (s0_rd_i),
    .s0_src_i(s0_src_i),
    .s1_wr_i (s1_wr_i),
    .s1_dst_i(s1_dst_i),
    .s1_rd_i (s1_rd_i),
    .s1_src_i(s1_src_i),
    .blk0_o  (blk0),
    .blk1_o  (blk1),
    .dep_o   (dep)
  );

  assign av0 = ~stall_i & (q_cnt_i != 2'd0);
  assign av1 = ~stall_i & q_cnt_i[1];

  pair_steer i_steer (
    .av0_i  (av0),
    .av1_i  (av1),
    .blk0_i (blk0),
    .blk1_i (blk1),
    .dep_i  (dep),
    .mask0_i(mask_a[0]),
    .mask1_i(mask_a[1]),
    .f_vld_o(f_vld_d),
    .f_sel_o(f_sel_d),
    .m_vld_o(m_vld_d),
    .m_sel_o(m_sel_d),
    .cnt_o  (cnt_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_vld_o <= 1'b0;
      f_sel_o <= 1'b0;
      m_vld_o <= 1'b0;
      m_sel_o <= 1'b0;
      cnt_o   <= 2'd0;
    end else begin
      f_vld_o <= f_vld_d;
      f_sel_o <= f_sel_d;
      m_vld_o <= m_vld_d;
      m_sel_o <= m_sel_d;
      cnt_o   <= cnt_d;
    end
  end

  a_r3_cnt_matches_pipes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o == ({1'b0, f_vld_o} + {1'b0, m_vld_o}));

  a_r3_distinct_slots: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f_vld_o && m_vld_o) |-> (f_sel_o != m_sel_o));

  a_r4_single_is_older: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == 2'd1) |-> !((f_vld_o && f_sel_o) || (m_vld_o && m_sel_o)));

  a_r10_stall_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stall_i) |-> (cnt_o == 2'd0));

  a_r9_empty_queue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(q_cnt_i) == 2'd0) |-> (cnt_o == 2'd0));

  a_r2_fpipe_no_ldst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    f_vld_o |-> ((f_sel_o ? $past(s1_cls_i) : $past(s0_cls_i)) != CLS_LDST));

  a_r2_mpipe_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_vld_o |-> (m_sel_o ? ($past(s1_cls_i) == CLS_LDST || ($past(s1_cls_i) == CLS_INT && !$past(s1_md_i)))
                         : ($past(s0_cls_i) == CLS_LDST || ($past(s0_cls_i) == CLS_INT && !$past(s0_md_i)))));
endmodule

// File: tb/test_dual_issue_pair.sv
module test_dual_issue_pair;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8;
  localparam int NSRC = 2;
  localparam int RW   = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic stall;
  logic [1:0] qc;
  logic [NREG-1:0] busy;
  logic [1:0] c [2];
  logic md [2], w [2];
  logic [RW-1:0] d [2], sa [2], sb [2];
  logic [1:0] rdm [2];
  logic f_vld, f_sel, m_vld, m_sel;
  logic [1:0] cnt;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_issue_pair #(.NREG(NREG), .NSRC(NSRC)) i_dual_issue_pair (
    .clk_i(clk), .rst_ni(rst_ni), .stall_i(stall), .q_cnt_i(qc), .busy_i(busy),
    .s0_cls_i(c[0]), .s0_md_i(md[0]), .s0_wr_i(w[0]), .s0_dst_i(d[0]),
    .s0_rd_i(rdm[0]), .s0_src_i({sb[0], sa[0]}),
    .s1_cls_i(c[1]), .s1_md_i(md[1]), .s1_wr_i(w[1]), .s1_dst_i(d[1]),
    .s1_rd_i(rdm[1]), .s1_src_i({sb[1], sa[1]}),
    .f_vld_o(f_vld), .f_sel_o(f_sel), .m_vld_o(m_vld), .m_sel_o(m_sel), .cnt_o(cnt)
  );

  function automatic logic src_busy(int i);
    return (rdm[i][0] && sa[i] != 0 && busy[sa[i]]) || (rdm[i][1] && sb[i] != 0 && busy[sb[i]]);
  endfunction

  function automatic logic pair_dep();
    if (!w[0] || d[0] == 0) return 1'b0;
    return (rdm[1][0] && sa[1] == d[0]) || (rdm[1][1] && sb[1] == d[0]) || (w[1] && d[1] == d[0]);
  endfunction

  // expected {f_vld, f_sel, m_vld, m_sel, cnt}
  function automatic logic [5:0] model();
    int n, issued;
    logic uf, um, go, af, am, fv, fs, mv, ms, yf;
    n = stall ? 0 : (qc > 2 ? 2 : int'(qc));
    uf = 0; um = 0; go = 1; fv = 0; fs = 0; mv = 0; ms = 0; issued = 0;
    yf = (c[1] != 2'd1) && !(c[1] == 2'd0 && !md[1]);
    for (int i = 0; i < 2; i++) begin
      if (i >= n) go = 0;
      if (go && src_busy(i)) go = 0;
      if (go && i == 1 && pair_dep()) go = 0;
      if (go) begin
        af = (c[i] != 2'd1);
        am = (c[i] == 2'd1) || (c[i] == 2'd0 && !md[i]);
        if (i == 0 && af && am && n >= 2 && yf) begin um = 1; mv = 1; ms = 0; end
        else if (af && !uf) begin uf = 1; fv = 1; fs = (i == 1); end
        else if (am && !um) begin um = 1; mv = 1; ms = (i == 1); end
        else go = 0;
        if (go) issued++;
      end
    end
    return {fv, fs, mv, ms, 2'(issued)};
  endfunction

  task automatic check(string tag, logic [5:0] exp);
    logic [5:0] got;
    got = {f_vld, f_sel, m_vld, m_sel, cnt};
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got f_vld=%b f_sel=%b m_vld=%b m_sel=%b cnt=%0d, expected f_vld=%b f_sel=%b m_vld=%b m_sel=%b cnt=%0d",
               tag, got[5], got[4], got[3], got[2], got[1:0], exp[5], exp[4], exp[3], exp[2], exp[1:0]);
    end
  endtask

  task automatic set_slot(int i, logic [1:0] cl, logic m, logic wr, int dst, logic [1:0] r, int a, int b);
    c[i] = cl; md[i] = m; w[i] = wr; d[i] = RW'(dst); rdm[i] = r; sa[i] = RW'(a); sb[i] = RW'(b);
  endtask

  task automatic idle();
    stall = 0; qc = 0; busy = '0;
    set_slot(0, 2'd0, 0, 0, 0, 2'b00, 0, 0);
    set_slot(1, 2'd0, 0, 0, 0, 2'b00, 0, 0);
  endtask

  // inputs are driven at a falling edge; the registered result is checked at the next one
  task automatic cyc(string tag);
    logic [5:0] exp;
    exp = model();
    @(negedge clk);
    check(tag, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle();
    qc = 2;
    set_slot(0, 2'd0, 0, 1, 1, 2'b00, 0, 0);
    set_slot(1, 2'd0, 0, 1, 2, 2'b00, 0, 0);
    @(negedge clk); @(negedge clk);
    check("R1 in reset", 6'b0);
    rst_ni = 1'b1;
    idle();
    cyc("R1 after reset");

    // R5: integer pair
    qc = 2;
    set_slot(0, 2'd0, 0, 1, 1, 2'b11, 2, 3);
    set_slot(1, 2'd0, 0, 1, 4, 2'b11, 5, 6);
    cyc("R5 int+int");
    // R11: one-cycle hold, then idle
    idle(); cyc("R11 no hold");
    qc = 2;
    set_slot(0, 2'd0, 0, 1, 1, 2'b01, 2, 0);
    set_slot(1, 2'd2, 0, 0, 0, 2'b01, 3, 0);
    cyc("R5 int+branch");
    qc = 2;
    set_slot(0, 2'd0, 0, 1, 1, 2'b00, 0, 0);
    set_slot(1, 2'd1, 0, 1, 2, 2'b01, 3, 0);
    cyc("R5 int+ldst");
    qc = 1;
    set_slot(1, 2'd3, 0, 0, 0, 2'b00, 0, 0);
    cyc("R5 int alone");
    // R6
    qc = 2;
    set_slot(0, 2'd1, 0, 1, 1, 2'b01, 2, 0);
    set_slot(1, 2'd1, 0, 1, 3, 2'b01, 4, 0);
    cyc("R6 ldst+ldst");
    set_slot(0, 2'd3, 0, 1, 1, 2'b00, 0, 0);
    set_slot(1, 2'd2, 0, 0, 0, 2'b00, 0, 0);
    cyc("R6 fp+branch");
    // R2
    set_slot(0, 2'd0, 1, 1, 1, 2'b00, 0, 0);
    set_slot(1, 2'd0, 0, 1, 2, 2'b00, 0, 0);
    cyc("R2 muldiv+int");
    set_slot(0, 2'd0, 0, 1, 1, 2'b00, 0, 0);
    set_slot(1, 2'd0, 1, 1, 2, 2'b00, 0, 0);
    cyc("R2 int+muldiv");
    set_slot(0, 2'd1, 1, 1, 1, 2'b00, 0, 0);
    set_slot(1, 2'd3, 1, 1, 2, 2'b00, 0, 0);
    cyc("R2 md ignored ldst+fp");
    set_slot(0, 2'd0, 1, 1, 1, 2'b00, 0, 0);
    set_slot(1, 2'd2, 0, 0, 0, 2'b00, 0, 0);
    cyc("R2 muldiv+branch");
    // R7
    set_slot(0, 2'd0, 0, 1, 3, 2'b00, 0, 0);
    set_slot(1, 2'd1, 0, 1, 4, 2'b10, 0, 3);
    cyc("R7 raw src b");
    set_slot(1, 2'd1, 0, 1, 4, 2'b01, 3, 0);
    cyc("R7 raw src a");
    set_slot(1, 2'd1, 0, 1, 4, 2'b10, 3, 5);
    cyc("R7 disabled source ignored");
    set_slot(1, 2'd1, 0, 1, 3, 2'b00, 0, 0);
    cyc("R7 waw");
    set_slot(0, 2'd0, 0, 1, 0, 2'b00, 0, 0);
    set_slot(1, 2'd1, 0, 1, 0, 2'b11, 0, 0);
    cyc("R7 register 0");
    // R8 and R4
    set_slot(0, 2'd0, 0, 1, 1, 2'b01, 2, 0);
    set_slot(1, 2'd1, 0, 1, 3, 2'b01, 4, 0);
    busy = 8'b0000_0100;
    cyc("R8 R4 older busy");
    busy = 8'b0001_0000;
    cyc("R8 younger busy");
    busy = 8'b0000_0001;
    set_slot(0, 2'd0, 0, 1, 1, 2'b11, 0, 0);
    cyc("R8 register 0 busy");
    busy = 8'b1111_1111;
    set_slot(0, 2'd2, 0, 0, 0, 2'b00, 0, 0);
    set_slot(1, 2'd1, 0, 0, 0, 2'b00, 0, 0);
    cyc("R8 no enabled sources");
    busy = '0;
    // R9 and R10
    set_slot(0, 2'd0, 0, 1, 1, 2'b00, 0, 0);
    set_slot(1, 2'd0, 0, 1, 2, 2'b00, 0, 0);
    qc = 0; cyc("R9 count 0");
    qc = 1; cyc("R9 count 1");
    qc = 3; cyc("R9 count 3");
    stall = 1; cyc("R10 stall");
    stall = 0; qc = 2; cyc("R10 after stall");

    // random run, compared every cycle
    for (int t = 0; t < 4000; t++) begin
      stall = ($urandom % 8) == 0;
      qc = 2'($urandom);
      busy = (($urandom % 3) == 0) ? NREG'($urandom) : '0;
      for (int i = 0; i < 2; i++)
        set_slot(i, 2'($urandom), 1'($urandom), 1'($urandom), int'($urandom % NREG),
                 2'($urandom), int'($urandom % NREG), int'($urandom % NREG));
      cyc("R3 R4 R11 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule